// File: doc/BRIEF.md
# UART DMA Ready Signal Generator

This block drives the two active-low ready lines that one UART channel presents to an external DMA controller: a transmit-ready line that asks for more bytes to be written, and a receive-ready line that asks for bytes to be read. It watches the fill levels of the transmit and receive FIFOs, the programmed trigger levels, a flag that says an errored character sits in the receive FIFO, and the serial receive line. It also contains the idle detector that raises the receive time-out.

Two signalling styles are supported. In single-transfer style the lines follow simple conditions: transmit-ready while the transmit store is empty, and receive-ready while at least one byte is held. Block-transfer style is used only when the FIFOs are enabled and block style is selected. In this style each line has a set rule and a clear rule, and it holds its state between them, so the DMA controller can move a whole block in each request. The receive line can also be raised by an idle time-out. It is dropped early when the flagged error is seen.

Top module: `dma_ready_gen`

## Requirements
- R1: While `rst_n` is low, `tx_rdy_n` and `rx_rdy_n` are 1 and `rx_timeout` is 0.
- R2: Block-transfer style applies only when `fifo_en`=1 and `dma_mode`=1. Every other combination uses the single-transfer rules.
- R3: Single-transfer style: `tx_rdy_n` is 0 exactly when `tx_level` was 0 at the previous clock edge.
- R4: Single-transfer style: `rx_rdy_n` is 0 exactly when `rx_level` was 1 or more at the previous clock edge.
- R5: Block-transfer style: `tx_rdy_n` goes to 0 when the free space (FIFO_DEPTH minus `tx_level`) is at least `tx_trig` and the FIFO is not full.
- R6: Block-transfer style: `tx_rdy_n` goes to 1 when `tx_level` equals FIFO_DEPTH. Between the set and clear conditions it keeps its value.
- R7: Block-transfer style: `rx_rdy_n` goes to 0 when `rx_level` is at least `rx_trig`. Otherwise it keeps its value unless a release condition applies.
- R8: Block-transfer style: `rx_rdy_n` goes to 0 one clock after `rx_timeout` is 1.
- R9: Block-transfer style: `rx_rdy_n` goes to 1 when `rx_level` is 0 or `rx_err_present` is 1. A release takes priority over any set condition in the same cycle.
- R10: `rx_timeout` rises on the clock edge that registers the 4×`frame_bits`-th `bit_tick` counted while `rx_line` is 1 and `rx_level` is nonzero.
- R11: Each of `rx_line`=0, `rx_char_done`=1, `rx_rd`=1 or `rx_level`=0 clears `rx_timeout` and restarts the idle count on the next edge.
- R12: All three outputs are registered. A change at the inputs is never visible at the outputs before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | 1 selects block-transfer style |
| tx_level | input | LVL_W | Bytes held in the transmit FIFO |
| rx_level | input | LVL_W | Bytes held in the receive FIFO |
| tx_trig | input | LVL_W | Free-space trigger for transmit requests |
| rx_trig | input | LVL_W | Fill trigger for receive requests |
| rx_err_present | input | 1 | An errored character is in the receive FIFO |
| rx_line | input | 1 | Serial receive line level |
| bit_tick | input | 1 | One pulse per bit time |
| frame_bits | input | FRM_W | Bits per character frame |
| rx_char_done | input | 1 | Pulse when a character has been received |
| rx_rd | input | 1 | Receive FIFO read strobe |
| tx_rdy_n | output | 1 | Transmit ready, active low |
| rx_rdy_n | output | 1 | Receive ready, active low |
| rx_timeout | output | 1 | Receive idle time-out |

## Verification
A wrong hold bit in block-transfer style appears at a ready pin on the first clock after the levels enter the band between the set and clear thresholds. A stale or missing clear shows up when the FIFO fills or empties. A wrong idle count appears at `rx_timeout` exactly one tick early or late, and at `rx_rdy_n` one clock after that. A reference model advanced on every edge therefore exposes any divergence on the very next cycle.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  typedef enum logic {
    DMR_SINGLE = 1'b0,
    DMR_BLOCK  = 1'b1
  } dmr_mode_e;
endpackage

// File: rtl/dmr_idle_timer.sv
module dmr_idle_timer #(
  parameter int LVL_W = 7,
  parameter int FRM_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             bit_tick,
  input  logic [FRM_W-1:0] frame_bits,
  input  logic             rx_char_done,
  input  logic             rx_rd,
  input  logic [LVL_W-1:0] rx_level,
  output logic             timeout
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_q, to_d;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             restart;

  assign limit   = CNT_W'({frame_bits, 2'b00});
  assign cnt_inc = cnt_q + 1'b1;
  assign restart = !rx_line || rx_char_done || rx_rd || (rx_level == '0);

  always_comb begin
    cnt_d = cnt_q;
    to_d  = to_q;
    if (restart) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (bit_tick && !to_q) begin
      cnt_d = cnt_inc;
      if (cnt_inc >= limit) to_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign timeout = to_q;
endmodule

// File: rtl/dmr_tx_ready.sv
module dmr_tx_ready
  import dmr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dmr_mode_e        mode,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  output logic             rdy_n
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic             act_q, act_d;
  logic [LVL_W-1:0] free_slots;

  assign free_slots = FULL - level;

  always_comb begin
    act_d = act_q;
    unique case (mode)
      DMR_SINGLE: act_d = (level == '0);
      DMR_BLOCK: begin
        if (level == FULL)          act_d = 1'b0;
        else if (free_slots >= trig) act_d = 1'b1;
      end
      default: act_d = act_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign rdy_n = ~act_q;
endmodule

// File: rtl/dmr_rx_ready.sv
module dmr_rx_ready
  import dmr_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dmr_mode_e        mode,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  input  logic             err_present,
  input  logic             timeout,
  output logic             rdy_n
);
  logic act_q, act_d;

  always_comb begin
    act_d = act_q;
    unique case (mode)
      DMR_SINGLE: act_d = (level != '0);
      DMR_BLOCK: begin
        if (level == '0 || err_present)  act_d = 1'b0;
        else if (level >= trig || timeout) act_d = 1'b1;
      end
      default: act_d = act_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign rdy_n = ~act_q;
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
  import dmr_pkg::*;
#(
  parameter int FIFO_DEPTH     = 64,
  parameter int MAX_FRAME_BITS = 12,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int FRM_W = $clog2(MAX_FRAME_BITS + 1),
  localparam int CNT_W = $clog2(4 * MAX_FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_err_present,
  input  logic             rx_line,
  input  logic             bit_tick,
  input  logic [FRM_W-1:0] frame_bits,
  input  logic             rx_char_done,
  input  logic             rx_rd,
  output logic             tx_rdy_n,
  output logic             rx_rdy_n,
  output logic             rx_timeout
);
  dmr_mode_e eff_mode;

  assign eff_mode = (fifo_en && dma_mode) ? DMR_BLOCK : DMR_SINGLE;

  dmr_idle_timer #(.LVL_W(LVL_W), .FRM_W(FRM_W), .CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_line      (rx_line),
    .bit_tick     (bit_tick),
    .frame_bits   (frame_bits),
    .rx_char_done (rx_char_done),
    .rx_rd        (rx_rd),
    .rx_level     (rx_level),
    .timeout      (rx_timeout)
  );

  dmr_tx_ready #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (eff_mode),
    .level (tx_level),
    .trig  (tx_trig),
    .rdy_n (tx_rdy_n)
  );

  dmr_rx_ready #(.LVL_W(LVL_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (eff_mode),
    .level       (rx_level),
    .trig        (rx_trig),
    .err_present (rx_err_present),
    .timeout     (rx_timeout),
    .rdy_n       (rx_rdy_n)
  );
endmodule

// File: rtl/dmr_ready_checker.sv
module dmr_ready_checker #(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             dma_mode,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_err_present,
  input logic             rx_line,
  input logic             bit_tick,
  input logic             tx_rdy_n,
  input logic             rx_rdy_n,
  input logic             rx_timeout
);
  logic blk;
  assign blk = fifo_en && dma_mode;

  a_r3_single_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && tx_level == '0) |=> !tx_rdy_n);

  a_r4_single_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && rx_level != '0) |=> !rx_rdy_n);

  a_r6_block_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && tx_level == LVL_W'(FIFO_DEPTH)) |=> tx_rdy_n);

  a_r9_block_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && (rx_level == '0 || rx_err_present)) |=> rx_rdy_n);

  a_r10_timeout_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_timeout) |-> $past(bit_tick));

  a_r11_line_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_line |=> !rx_timeout);
endmodule

bind dma_ready_gen dmr_ready_checker #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/dma_ready_gen_bench.sv
module dma_ready_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LW = 7;
  localparam int FW = 4;

  logic clk, rst_n, fifo_en, dma_mode, rx_err_present, rx_line, bit_tick;
  logic rx_char_done, rx_rd;
  logic [LW-1:0] tx_level, rx_level, tx_trig, rx_trig;
  logic [FW-1:0] frame_bits;
  logic tx_rdy_n, rx_rdy_n, rx_timeout;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  dma_ready_gen u_dma_ready_gen (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_cnt;
  bit m_to, m_tx, m_rx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_to = 0; m_tx = 0; m_rx = 0;
    end else begin
      bit blk;
      blk = fifo_en && dma_mode;
      if (!blk) m_tx = (tx_level == 0);
      else if (tx_level == DEPTH) m_tx = 0;
      else if (DEPTH - int'(tx_level) >= int'(tx_trig)) m_tx = 1;
      if (!blk) m_rx = (rx_level != 0);
      else if (rx_level == 0 || rx_err_present) m_rx = 0;
      else if (rx_level >= rx_trig || m_to) m_rx = 1;
      if (!rx_line || rx_char_done || rx_rd || rx_level == 0) begin
        m_cnt = 0; m_to = 0;
      end else if (bit_tick && !m_to) begin
        m_cnt++;
        if (m_cnt >= 4 * int'(frame_bits)) m_to = 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R12: registered outputs compared with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12", "cycle tx_rdy_n", tx_rdy_n, ~m_tx);
      chk("R12", "cycle rx_rdy_n", rx_rdy_n, ~m_rx);
      chk("R12", "cycle rx_timeout", rx_timeout, m_to);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step(1);
      bit_tick = 1'b0; step(1);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; fifo_en = 0; dma_mode = 0; rx_err_present = 0; rx_line = 1;
    bit_tick = 0; rx_char_done = 0; rx_rd = 0; tx_level = 0; rx_level = 0;
    tx_trig = 8; rx_trig = 8; frame_bits = 3;
    step(3);
    chk("R1", "reset tx_rdy_n", tx_rdy_n, 1'b1);
    chk("R1", "reset rx_rdy_n", rx_rdy_n, 1'b1);
    chk("R1", "reset rx_timeout", rx_timeout, 1'b0);
    rst_n = 1;
    step(1);
    chk("R3", "single tx empty", tx_rdy_n, 1'b0);
    chk("R4", "single rx empty", rx_rdy_n, 1'b1);
    tx_level = 5; rx_level = 1;
    #2;
    chk("R12", "no change before edge", tx_rdy_n, 1'b0);
    step(1);
    chk("R3", "single tx not empty", tx_rdy_n, 1'b1);
    chk("R4", "single rx one byte", rx_rdy_n, 1'b0);
    fifo_en = 1; dma_mode = 0; step(2);
    chk("R2", "fifo on, single style", tx_rdy_n, 1'b1);
    fifo_en = 0; dma_mode = 1; step(2);
    chk("R2", "fifo off forces single", tx_rdy_n, 1'b1);
    fifo_en = 1; step(1);
    chk("R5", "block tx free>=trig", tx_rdy_n, 1'b0);
    rx_level = 0; step(1);
    chk("R9", "block rx empty release", rx_rdy_n, 1'b1);
    rx_level = 4; step(2);
    chk("R7", "block rx below trig holds", rx_rdy_n, 1'b1);
    rx_level = 8; step(1);
    chk("R7", "block rx at trig", rx_rdy_n, 1'b0);
    rx_level = 5; step(2);
    chk("R7", "block rx hold above empty", rx_rdy_n, 1'b0);
    rx_err_present = 1; step(1);
    chk("R9", "block rx error release", rx_rdy_n, 1'b1);
    rx_err_present = 0; step(2);
    chk("R9", "block rx stays released", rx_rdy_n, 1'b1);
    tx_level = 60; step(2);
    chk("R6", "block tx hold in band", tx_rdy_n, 1'b0);
    tx_level = 64; step(1);
    chk("R6", "block tx full release", tx_rdy_n, 1'b1);
    tx_level = 60; step(2);
    chk("R6", "block tx stays released", tx_rdy_n, 1'b1);
    tx_level = 56; step(1);
    chk("R5", "block tx free equals trig", tx_rdy_n, 1'b0);
    ticks(11);
    chk("R10", "no timeout after 11 ticks", rx_timeout, 1'b0);
    bit_tick = 1; step(1); bit_tick = 0;
    chk("R10", "timeout on 12th tick", rx_timeout, 1'b1);
    chk("R8", "rx not yet raised", rx_rdy_n, 1'b1);
    step(1);
    chk("R8", "rx raised by timeout", rx_rdy_n, 1'b0);
    rx_rd = 1; step(1); rx_rd = 0;
    chk("R11", "read clears timeout", rx_timeout, 1'b0);
    chk("R7", "rx holds after read", rx_rdy_n, 1'b0);
    ticks(5);
    rx_char_done = 1; step(1); rx_char_done = 0;
    ticks(11);
    chk("R11", "char restarts count", rx_timeout, 1'b0);
    ticks(1);
    chk("R10", "timeout after restart", rx_timeout, 1'b1);
    rx_line = 0; step(1); rx_line = 1;
    chk("R11", "line low clears", rx_timeout, 1'b0);
    rx_level = 0; step(1);
    chk("R9", "empty releases rx", rx_rdy_n, 1'b1);
    rx_level = 8; rx_err_present = 1; step(1);
    chk("R9", "release wins over set", rx_rdy_n, 1'b1);
    rx_err_present = 0; step(1);
    chk("R7", "set after error gone", rx_rdy_n, 1'b0);
    fifo_en = 0; rx_level = 0; tx_level = 0; step(1);
    chk("R3", "back to single tx", tx_rdy_n, 1'b0);
    chk("R4", "back to single rx", rx_rdy_n, 1'b1);
    step(2);
    finish_run();
  end
endmodule